// File: doc/BRIEF.md
# Descriptor-Driven Raster Timing Generator

This block produces progressive video raster timing (horizontal and vertical counters, horizontal and vertical sync, a data-enable strobe and the pixel coordinates) from the packed 18-byte detailed timing descriptor used by standard display identification data. Software or a loader state machine writes the descriptor one byte at a time through an address, data and write-strobe port. The block decodes the split fields internally: the 12-bit sizes built from a low byte and a shared nibble, and the sync offsets and widths built from low bits and a shared packed byte.

The decoded timing is not used at once. A commit strobe copies the decoded fields into a staging register. The running raster picks up the staged set only at the next frame wrap, so a reconfiguration never produces a torn line or frame. Each line starts with its active pixels and ends with blanking, and each frame is laid out the same way in lines. Sync position is counted from the start of blanking. Sync polarity comes from the flags byte. The 16-bit pixel-clock code and the interlace flag of the running configuration are passed out for the clock synthesizer and the downstream logic. The raster itself is always progressive.

Top module: `dtd_raster_gen`

## Requirements
- R1: While reset is held and after it releases, the running timing is the parameter default set (defaults: 8 active and 4 blanking pixels, 4 active and 2 blanking lines, hsync offset 1 and width 2, vsync offset 0 and width 1, both polarities active-high, pixel-clock code 0x0A8C, interlace 0), and the counters start at pixel 0 of line 0.
- R2: Horizontal active is {byte4[7:4], byte2} and horizontal blanking is {byte4[3:0], byte3}. A line lasts active plus blanking clocks, and the horizontal count runs from 0 up to that total minus one.
- R3: Vertical active is {byte7[7:4], byte5} and vertical blanking is {byte7[3:0], byte6}. A frame lasts active plus blanking lines, and the line count advances on the last pixel of each line.
- R4: `de` is high exactly when the pixel count is below horizontal active and the line count is below vertical active. `pix_x`/`pix_y` equal the counts while `de` is high and are 0 otherwise.
- R5: The horizontal sync region covers pixel counts c with HA+HSO <= c < HA+HSO+HSW, where HSO = {byte11[7:6], byte8} and HSW = {byte11[5:4], byte9}.
- R6: The vertical sync region covers line counts l with VA+VSO <= l < VA+VSO+VSW, where VSO = {byte11[3:2], byte10[7:4]} and VSW = {byte11[1:0], byte10[3:0]}.
- R7: byte17 bit 1 sets the hsync polarity and bit 2 the vsync polarity. A 1 drives the pin high inside its sync region and low outside it. A 0 inverts this.
- R8: Byte writes alone never change the running timing. A commit captures the decoded bytes, and the capture takes effect at the first frame wrap that follows the commit cycle. A commit given in the very cycle of a wrap applies at the following wrap.
- R9: `pclk_code` is {byte1, byte0} and `interlace` is byte17 bit 7, both taken from the running configuration. The interlace flag does not change the raster.
- R10: Writes to addresses 18 and above change nothing. Bytes 12 to 16 and the other bits of byte17 are stored but affect no output.
- R11: `frame_start` is high exactly while both counts are zero, that is in the cycle after every frame wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Descriptor byte write strobe |
| cfg_addr | input | 5 | Descriptor byte index |
| cfg_wdata | input | 8 | Descriptor byte value |
| cfg_commit | input | 1 | Stage the decoded descriptor for the next frame wrap |
| hsync | output | 1 | Horizontal sync, polarity per descriptor |
| vsync | output | 1 | Vertical sync, polarity per descriptor |
| de | output | 1 | Active-video data enable |
| pix_x | output | 12 | Pixel column during active video, else 0 |
| pix_y | output | 12 | Pixel row during active video, else 0 |
| frame_start | output | 1 | First pixel of a frame |
| pclk_code | output | 16 | Running pixel-clock code in 10 kHz units |
| interlace | output | 1 | Running interlace flag (informational) |

## Verification
A wrong horizontal count shows at `pix_x` and `de` within the same line. A wrong line count, or a wrong line advance, shows at `pix_y`, `vsync` and `frame_start` by the next line boundary at the latest. A misdecoded field or a misrouted shadow copy shows at `pclk_code` in the first cycle after the frame wrap that applies it. It also shifts the `de` and sync edges within one frame. The bench therefore compares every output on every clock with a behavioural model. It uses descriptor values that set every upper nibble and packed upper bit, so a swapped or truncated field moves an observable edge.

// File: rtl/dtd_pkg.sv
package dtd_pkg;

  localparam int DESC_BYTES = 18;
  localparam int ADDR_W     = 5;
  localparam int SIZE_W     = 12;
  localparam int HOFS_W     = 10;
  localparam int VOFS_W     = 6;
  localparam int PCLK_W     = 16;
  localparam int CNT_W      = SIZE_W + 1;

  typedef struct packed {
    logic [PCLK_W-1:0] pclk;
    logic [SIZE_W-1:0] hact;
    logic [SIZE_W-1:0] hblk;
    logic [SIZE_W-1:0] vact;
    logic [SIZE_W-1:0] vblk;
    logic [HOFS_W-1:0] hso;
    logic [HOFS_W-1:0] hsw;
    logic [VOFS_W-1:0] vso;
    logic [VOFS_W-1:0] vsw;
    logic              hpol;
    logic              vpol;
    logic              ilace;
  } timing_t;

endpackage

// File: rtl/dtd_byte_regs.sv
module dtd_byte_regs
  import dtd_pkg::*;
#(
  parameter int NUM_BYTES = DESC_BYTES,
  parameter int AW        = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output timing_t       dec
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(NUM_BYTES - 1);

  logic [NUM_BYTES-1:0][7:0] byte_q;
  logic [NUM_BYTES-1:0][7:0] byte_d;
  logic                      wr_en;
  logic                      unused_bits;

  // next-state
  always_comb begin
    wr_en  = we && (addr <= LAST_ADDR);
    byte_d = byte_q;
    if (wr_en) begin
      byte_d[addr] = wdata;
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
    end else if (wr_en) begin
      byte_q <= byte_d;
    end
  end

  // field decode: sizes are low byte plus shared nibble, sync fields low bits plus packed pairs
  always_comb begin
    dec.pclk  = {byte_q[1], byte_q[0]};
    dec.hact  = {byte_q[4][7:4], byte_q[2]};
    dec.hblk  = {byte_q[4][3:0], byte_q[3]};
    dec.vact  = {byte_q[7][7:4], byte_q[5]};
    dec.vblk  = {byte_q[7][3:0], byte_q[6]};
    dec.hso   = {byte_q[11][7:6], byte_q[8]};
    dec.hsw   = {byte_q[11][5:4], byte_q[9]};
    dec.vso   = {byte_q[11][3:2], byte_q[10][7:4]};
    dec.vsw   = {byte_q[11][1:0], byte_q[10][3:0]};
    dec.hpol  = byte_q[17][1];
    dec.vpol  = byte_q[17][2];
    dec.ilace = byte_q[17][7];
  end

  assign unused_bits = ^{byte_q[16:12], byte_q[17][6:3], byte_q[17][0]};

  AST_HIGH_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (addr > LAST_ADDR)) |=> $stable(byte_q)); // R10

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (addr <= LAST_ADDR)) |=> (byte_q[$past(addr)] == $past(wdata))); // R10

endmodule

// File: rtl/dtd_shadow.sv
module dtd_shadow
  import dtd_pkg::*;
#(
  parameter timing_t RST_CFG = '0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    commit,
  input  logic    frame_wrap,
  input  timing_t dec,
  output timing_t act
);

  timing_t staged_q;
  timing_t act_q;
  logic    pend_q;
  logic    pend_d;
  logic    apply;

  // next-state
  always_comb begin
    apply  = frame_wrap && pend_q;
    pend_d = pend_q;
    if (apply) begin
      pend_d = 1'b0;
    end
    if (commit) begin
      pend_d = 1'b1;
    end
  end

  // registers with written-out load enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= RST_CFG;
      act_q    <= RST_CFG;
      pend_q   <= 1'b0;
    end else begin
      if (commit) begin
        staged_q <= dec;
      end
      if (apply) begin
        act_q <= staged_q;
      end
      pend_q <= pend_d;
    end
  end

  assign act = act_q;

  AST_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(act_q)); // R8

  AST_COMMIT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> pend_q); // R8

  AST_APPLY_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wrap && pend_q) |=> (act_q == $past(staged_q))); // R8

endmodule

// File: rtl/raster_axis.sv
module raster_axis
  import dtd_pkg::*;
#(
  parameter int AW = SIZE_W,
  parameter int OW = HOFS_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [AW-1:0] len_act,
  input  logic [AW-1:0] len_blk,
  input  logic [OW-1:0] sync_off,
  input  logic [OW-1:0] sync_len,
  output logic [CW-1:0] pos,
  output logic          last,
  output logic          in_act,
  output logic          sync_on
);

  logic [CW-1:0] pos_q;
  logic [CW-1:0] pos_d;
  logic [CW-1:0] total;
  logic [CW-1:0] sync_lo;
  logic [CW-1:0] sync_hi;

  // next-state
  always_comb begin
    total   = CW'(len_act) + CW'(len_blk);
    last    = (pos_q + CW'(1)) >= total;
    pos_d   = last ? '0 : pos_q + CW'(1);
    sync_lo = CW'(len_act) + CW'(sync_off);
    sync_hi = sync_lo + CW'(sync_len);
    in_act  = pos_q < CW'(len_act);
    sync_on = (pos_q >= sync_lo) && (pos_q < sync_hi);
  end

  // register with clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (adv) begin
      pos_q <= pos_d;
    end
  end

  assign pos = pos_q;

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (total != '0) |-> (pos_q < total)); // R2 R3

  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !last) |=> (pos_q == $past(pos_q) + CW'(1))); // R2 R3

  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pos_q)); // R3

endmodule

// File: rtl/dtd_raster_gen.sv
module dtd_raster_gen
  import dtd_pkg::*;
#(
  parameter logic [PCLK_W-1:0] RST_PCLK = 16'h0A8C,
  parameter logic [SIZE_W-1:0] RST_HACT = 12'd8,
  parameter logic [SIZE_W-1:0] RST_HBLK = 12'd4,
  parameter logic [SIZE_W-1:0] RST_VACT = 12'd4,
  parameter logic [SIZE_W-1:0] RST_VBLK = 12'd2,
  parameter logic [HOFS_W-1:0] RST_HSO  = 10'd1,
  parameter logic [HOFS_W-1:0] RST_HSW  = 10'd2,
  parameter logic [VOFS_W-1:0] RST_VSO  = 6'd0,
  parameter logic [VOFS_W-1:0] RST_VSW  = 6'd1,
  parameter logic              RST_HPOL = 1'b1,
  parameter logic              RST_VPOL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              cfg_commit,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [SIZE_W-1:0] pix_x,
  output logic [SIZE_W-1:0] pix_y,
  output logic              frame_start,
  output logic [PCLK_W-1:0] pclk_code,
  output logic              interlace
);

  localparam timing_t RST_CFG = '{pclk: RST_PCLK, hact: RST_HACT, hblk: RST_HBLK,
                                  vact: RST_VACT, vblk: RST_VBLK, hso: RST_HSO,
                                  hsw: RST_HSW, vso: RST_VSO, vsw: RST_VSW,
                                  hpol: RST_HPOL, vpol: RST_VPOL, ilace: 1'b0};

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  timing_t          dec;
  timing_t          act;
  logic [CNT_W-1:0] h_pos;
  logic [CNT_W-1:0] v_pos;
  logic             h_last;
  logic             v_last;
  logic             h_in;
  logic             v_in;
  logic             h_sync_on;
  logic             v_sync_on;
  logic             frame_wrap;
  logic             unused_bits;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  dtd_byte_regs #(.NUM_BYTES(DESC_BYTES), .AW(ADDR_W)) u_bytes (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .dec   (dec)
  );

  dtd_shadow #(.RST_CFG(RST_CFG)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .commit     (cfg_commit),
    .frame_wrap (frame_wrap),
    .dec        (dec),
    .act        (act)
  );

  raster_axis #(.AW(SIZE_W), .OW(HOFS_W), .CW(CNT_W)) u_h_axis (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .adv      (1'b1),
    .len_act  (act.hact),
    .len_blk  (act.hblk),
    .sync_off (act.hso),
    .sync_len (act.hsw),
    .pos      (h_pos),
    .last     (h_last),
    .in_act   (h_in),
    .sync_on  (h_sync_on)
  );

  raster_axis #(.AW(SIZE_W), .OW(VOFS_W), .CW(CNT_W)) u_v_axis (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .adv      (h_last),
    .len_act  (act.vact),
    .len_blk  (act.vblk),
    .sync_off (act.vso),
    .sync_len (act.vsw),
    .pos      (v_pos),
    .last     (v_last),
    .in_act   (v_in),
    .sync_on  (v_sync_on)
  );

  // output decode
  always_comb begin
    frame_wrap  = h_last && v_last;
    de          = h_in && v_in;
    pix_x       = de ? h_pos[SIZE_W-1:0] : '0;
    pix_y       = de ? v_pos[SIZE_W-1:0] : '0;
    hsync       = h_sync_on ? act.hpol : ~act.hpol;
    vsync       = v_sync_on ? act.vpol : ~act.vpol;
    frame_start = (h_pos == '0) && (v_pos == '0);
    pclk_code   = act.pclk;
    interlace   = act.ilace;
  end

  assign unused_bits = h_pos[CNT_W-1] ^ v_pos[CNT_W-1];

  AST_HSYNC_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_int_n)
    h_sync_on |-> !de); // R5

  AST_VSYNC_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_int_n)
    v_sync_on |-> !de); // R6

  AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_int_n)
    frame_wrap |=> frame_start); // R11

  AST_CODE_STABLE_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_int_n)
    !frame_wrap |=> $stable(pclk_code)); // R8

endmodule

// File: tb/dtd_raster_gen_tb.sv
module dtd_raster_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        cfg_commit = 1'b0;
  logic        hsync, vsync, de, frame_start, interlace;
  logic [11:0] pix_x, pix_y;
  logic [15:0] pclk_code;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  // model state: 0 ha,1 hb,2 va,3 vb,4 hso,5 hsw,6 vso,7 vsw,8 hpol,9 vpol,10 ilace,11 pclk
  int mb[18];
  int st[12];
  int ac[12];
  int dflt[12] = '{8, 4, 4, 2, 1, 2, 0, 1, 1, 1, 0, 32'h0A8C};
  int mh, mv;
  bit mpend;
  bit ms1 = 1'b0, ms2 = 1'b0;

  always #5 clk = ~clk;

  dtd_raster_gen #(
    .RST_PCLK(16'h0A8C), .RST_HACT(12'd8), .RST_HBLK(12'd4), .RST_VACT(12'd4),
    .RST_VBLK(12'd2), .RST_HSO(10'd1), .RST_HSW(10'd2), .RST_VSO(6'd0),
    .RST_VSW(6'd1), .RST_HPOL(1'b1), .RST_VPOL(1'b1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_commit(cfg_commit), .hsync(hsync), .vsync(vsync),
    .de(de), .pix_x(pix_x), .pix_y(pix_y), .frame_start(frame_start),
    .pclk_code(pclk_code), .interlace(interlace)
  );

  task automatic chk(input string tag, input string what, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, actual, expected, cyc);
    end
  endtask

  task automatic model_reset();
    mh = 0; mv = 0; mpend = 1'b0;
    ac = dflt; st = dflt;
    foreach (mb[i]) mb[i] = 0;
  endtask

  task automatic model_decode();
    st[0]  = mb[2] + ((mb[4] >> 4) & 15) * 256;
    st[1]  = mb[3] + (mb[4] & 15) * 256;
    st[2]  = mb[5] + ((mb[7] >> 4) & 15) * 256;
    st[3]  = mb[6] + (mb[7] & 15) * 256;
    st[4]  = mb[8] + ((mb[11] >> 6) & 3) * 256;
    st[5]  = mb[9] + ((mb[11] >> 4) & 3) * 256;
    st[6]  = ((mb[10] >> 4) & 15) + ((mb[11] >> 2) & 3) * 16;
    st[7]  = (mb[10] & 15) + (mb[11] & 3) * 16;
    st[8]  = (mb[17] >> 1) & 1;
    st[9]  = (mb[17] >> 2) & 1;
    st[10] = (mb[17] >> 7) & 1;
    st[11] = mb[0] + mb[1] * 256;
  endtask

  task automatic model_step();
    int htot, vtot;
    bit hl, vl, fw;
    htot = ac[0] + ac[1];
    vtot = ac[2] + ac[3];
    hl = (mh + 1 >= htot);
    vl = (mv + 1 >= vtot);
    fw = hl && vl;
    if (hl) begin
      mh = 0;
      if (vl) mv = 0; else mv = mv + 1;
    end else begin
      mh = mh + 1;
    end
    if (fw && mpend) begin
      ac = st;
      mpend = 1'b0;
    end
    if (cfg_commit) begin
      model_decode();
      mpend = 1'b1;
    end
    if (cfg_we && cfg_addr < 18) mb[cfg_addr] = int'(cfg_wdata);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      model_reset();
      ms1 = 1'b0; ms2 = 1'b0;
    end else begin
      if (!ms2) model_reset(); else model_step();
      ms2 = ms1; ms1 = 1'b1;
    end
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (chk_on && !done) begin
      bit ede, ehs, evs;
      ede = (mh < ac[0]) && (mv < ac[2]);
      ehs = (mh >= ac[0] + ac[4]) && (mh < ac[0] + ac[4] + ac[5]);
      evs = (mv >= ac[2] + ac[6]) && (mv < ac[2] + ac[6] + ac[7]);
      chk("R4", "de", int'(de), int'(ede));
      chk("R2", "pix_x", int'(pix_x), ede ? mh : 0);
      chk("R3", "pix_y", int'(pix_y), ede ? mv : 0);
      chk("R5", "hsync", int'(hsync), ehs ? ac[8] : 1 - ac[8]);
      chk("R6", "vsync", int'(vsync), evs ? ac[9] : 1 - ac[9]);
      chk("R11", "frame_start", int'(frame_start), (mh == 0 && mv == 0) ? 1 : 0);
      chk("R9", "pclk_code", int'(pclk_code), ac[11]);
      chk("R9", "interlace", int'(interlace), ac[10]);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic commit();
    @(negedge clk);
    cfg_commit = 1'b1;
    @(negedge clk);
    cfg_commit = 1'b0;
  endtask

  task automatic wait_fs();
    @(negedge clk);
    while (!frame_start) @(negedge clk);
  endtask

  task automatic load_cfg(input int ha, input int hb, input int va, input int vb,
                          input int hso, input int hsw, input int vso, input int vsw,
                          input int hp, input int vp, input int il, input int pc);
    int b[18];
    b[0] = pc & 255;  b[1] = (pc >> 8) & 255;
    b[2] = ha & 255;  b[3] = hb & 255;
    b[4] = (((ha >> 8) & 15) << 4) | ((hb >> 8) & 15);
    b[5] = va & 255;  b[6] = vb & 255;
    b[7] = (((va >> 8) & 15) << 4) | ((vb >> 8) & 15);
    b[8] = hso & 255; b[9] = hsw & 255;
    b[10] = ((vso & 15) << 4) | (vsw & 15);
    b[11] = (((hso >> 8) & 3) << 6) | (((hsw >> 8) & 3) << 4) |
            (((vso >> 4) & 3) << 2) | ((vsw >> 4) & 3);
    for (int i = 12; i < 17; i++) b[i] = 8'hA5;
    b[17] = (il << 7) | (vp << 2) | (hp << 1) | 8'h18;
    for (int i = 0; i < 18; i++) wr(i, b[i]);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_on = 1'b1;
    // R1: reset state
    chk("R1", "de in reset", int'(de), 1);
    chk("R1", "frame_start in reset", int'(frame_start), 1);
    chk("R1", "hsync in reset", int'(hsync), 0);
    chk("R1", "vsync in reset", int'(vsync), 0);
    chk("R1", "pclk_code in reset", int'(pclk_code), 16'h0A8C);
    chk("R1", "pix_x in reset", int'(pix_x), 0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_fs(); wait_fs();

    // config A written without commit: R8 no effect
    load_cfg(10, 6, 5, 3, 2, 3, 1, 1, 1, 0, 0, 16'h1D01);
    wait_fs(); wait_fs();
    chk("R8", "pclk_code before commit", int'(pclk_code), 16'h0A8C);
    repeat (5) @(negedge clk);
    commit();
    chk("R8", "pclk_code mid-frame after commit", int'(pclk_code), 16'h0A8C);
    wait_fs();
    chk("R8", "pclk_code after boundary", int'(pclk_code), 16'h1D01);
    chk("R7", "hsync idle level", int'(hsync), 0);
    chk("R7", "vsync idle level low-active", int'(vsync), 1);
    wait_fs(); wait_fs(); wait_fs();

    // R10: out-of-range addresses
    for (int a = 18; a < 32; a++) wr(a, 8'hFF);
    commit();
    wait_fs(); wait_fs();
    chk("R10", "pclk_code after high-address writes", int'(pclk_code), 16'h1D01);
    chk("R10", "interlace after high-address writes", int'(interlace), 0);
    wait_fs();

    // config B: horizontal upper nibbles and packed hsync upper bits
    load_cfg(256, 261, 2, 3, 257, 2, 0, 2, 0, 1, 0, 16'h2710);
    commit();
    wait_fs();
    chk("R2", "pclk_code config B", int'(pclk_code), 16'h2710);
    wait_fs(); wait_fs(); wait_fs();

    // config C: vertical upper nibbles, packed vsync upper bits, interlace flag, both polarities low
    load_cfg(4, 4, 257, 40, 1, 2, 17, 18, 0, 0, 1, 16'h0BB8);
    commit();
    wait_fs();
    chk("R9", "interlace flag config C", int'(interlace), 1);
    chk("R7", "hsync idle high when active-low", int'(hsync), 1);
    wait_fs(); wait_fs(); wait_fs();

    // R8: commit in the very cycle of a frame wrap applies one frame later
    load_cfg(10, 6, 5, 3, 2, 3, 1, 1, 1, 0, 0, 16'h1234);
    @(negedge clk);
    while (!((mh + 1 >= ac[0] + ac[1]) && (mv + 1 >= ac[2] + ac[3]))) @(negedge clk);
    cfg_commit = 1'b1;
    @(negedge clk);
    cfg_commit = 1'b0;
    chk("R8", "frame_start after wrap commit", int'(frame_start), 1);
    chk("R8", "pclk_code held after wrap commit", int'(pclk_code), 16'h0BB8);
    wait_fs();
    chk("R8", "pclk_code one frame later", int'(pclk_code), 16'h1234);
    wait_fs(); wait_fs();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule